// File: doc/BRIEF.md
# Cyclic Prefix Framer and Deframer

This block sits on both sides of a block-based multicarrier link. On the transmit path it collects a serial symbol stream into blocks of `BLK` samples. It sends each block as a frame of `BLK + PFX` samples: first a copy of the block's final `PFX` samples, in their original order, and then the whole block. The transmit sample rate therefore rises by a factor of `(BLK + PFX) / BLK`.

On the receive path the block aligns to frame boundaries marked by a start-of-frame flag on the channel samples. It discards the first `PFX` samples of every frame and forwards the remaining `BLK` samples to a downstream transform, marking the last of them. Because the discarded span is at least as long as the channel memory, the linear channel looks circular over the kept samples.

Every data path uses a valid/ready handshake. A transfer happens on a rising clock edge where valid and ready are both high. Once a source raises valid, it holds valid and its data until the transfer. On the transmit output, a low `tx_out_ready` freezes the frame position, so no sample is lost or repeated. On the receive side, samples that are being discarded are always accepted. A sample that is being kept is accepted only when `rx_out_ready` is high, because it passes straight through to the output.

`PFX` must be at least 1 and below `BLK`.

Top module: `cpx_unit`

## Requirements
- R1: While reset (`rst_n` low) is active and after its release, `tx_in_ready` is 1, `tx_out_valid` is 0 and `rx_out_valid` is 0 until stimulus arrives.
- R2: The transmit side accepts exactly `BLK` input samples. It then holds `tx_in_ready` low until the whole frame has been sent. `tx_in_ready` and `tx_out_valid` are never high together.
- R3: Each transmit frame has `BLK + PFX` samples: input samples `BLK-PFX` through `BLK-1` of the block, then samples 0 through `BLK-1`, each in input order.
- R4: `tx_out_sof` is 1 only on the first prefix sample of a frame. `tx_out_last` is 1 only on the final sample of a frame.
- R5: While `tx_out_valid` is 1 and `tx_out_ready` is 0, the next cycle shows the same `tx_out_data`, `tx_out_sof` and `tx_out_last` with `tx_out_valid` still 1.
- R6: Until the first sample with `rx_in_sof` = 1 is seen, every receive sample is accepted (`rx_in_ready` = 1) and nothing is output.
- R7: A sample with `rx_in_sof` = 1 is frame index 0. Indices 0 to `PFX-1` are discarded, and indices `PFX` to `BLK+PFX-1` are forwarded in order with unchanged data.
- R8: `rx_out_last` is 1 exactly on the forwarded sample of frame index `BLK+PFX-1`, the `BLK`-th kept sample.
- R9: For a kept sample, `rx_in_ready` equals `rx_out_ready`. For a discarded sample, `rx_in_ready` is 1 regardless of `rx_out_ready`.
- R10: A sample with `rx_in_sof` = 1 that arrives part way through a frame restarts the frame count at index 0.
- R11: After frame index `BLK+PFX-1`, the next sample is index 0 of a new frame even without `rx_in_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_in_valid | input | 1 | Transmit symbol valid |
| tx_in_ready | output | 1 | Transmit side can take a symbol |
| tx_in_data | input | DW | Transmit symbol |
| tx_out_valid | output | 1 | Framed sample valid |
| tx_out_ready | input | 1 | Channel can take a framed sample |
| tx_out_data | output | DW | Framed sample |
| tx_out_sof | output | 1 | First prefix sample of a frame |
| tx_out_last | output | 1 | Final sample of a frame |
| rx_in_valid | input | 1 | Channel sample valid |
| rx_in_ready | output | 1 | Channel sample accepted |
| rx_in_data | input | DW | Channel sample |
| rx_in_sof | input | 1 | Channel sample is frame index 0 |
| rx_out_valid | output | 1 | Kept sample valid |
| rx_out_ready | input | 1 | Downstream can take a kept sample |
| rx_out_data | output | DW | Kept sample |
| rx_out_last | output | 1 | Last kept sample of the frame |

## Verification
A wrong transmit read address shows on the next output transfer as a sample out of order. It appears first at the wrap from the prefix into the body, or at the start of the prefix. A slip in the transmit sequence counter moves `tx_out_sof`/`tx_out_last` and changes the frame length. The change is visible within one frame, because `tx_in_ready` returns one beat early or late. On the receive side, a wrong position counter or lock flag changes which samples are forwarded in the very next cycle that carries data. The bench's per-cycle model compares ready, valid, data and both flags on every cycle. It drives random back-pressure on both sides and a receive script that includes unaligned junk, an unflagged back-to-back frame and a mid-frame realignment.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
  typedef enum logic {
    PH_FILL = 1'b0,
    PH_SEND = 1'b1
  } tx_phase_e;
endpackage

// File: rtl/cpx_insert.sv
module cpx_insert
  import cpx_pkg::*;
#(
  parameter int DW  = 16,
  parameter int BLK = 8,
  parameter int PFX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_last
);
  localparam int FRM = BLK + PFX;
  localparam int AW  = (BLK > 1) ? $clog2(BLK) : 1;
  localparam int SW  = $clog2(FRM);
  localparam logic [AW-1:0] TAIL_START = AW'(BLK - PFX);
  localparam logic [AW-1:0] ADDR_TOP   = AW'(BLK - 1);
  localparam logic [SW-1:0] SEQ_TOP    = SW'(FRM - 1);

  tx_phase_e     phase;
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_addr;
  logic [SW-1:0] seq;
  logic [DW-1:0] mem [BLK];

  logic take_in, give_out;
  assign take_in  = in_valid && in_ready;
  assign give_out = out_valid && out_ready;

  // The block store has no reset; it is only read after a full block was written.
  always_ff @(posedge clk) begin
    if (take_in) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_FILL;
      wr_ptr  <= '0;
      rd_addr <= '0;
      seq     <= '0;
    end else begin
      unique case (phase)
        PH_FILL: begin
          if (take_in) begin
            if (wr_ptr == ADDR_TOP) begin
              wr_ptr  <= '0;
              phase   <= PH_SEND;
              seq     <= '0;
              rd_addr <= TAIL_START;
            end else begin
              wr_ptr <= wr_ptr + 1'b1;
            end
          end
        end
        PH_SEND: begin
          if (give_out) begin
            if (seq == SEQ_TOP) begin
              phase <= PH_FILL;
              seq   <= '0;
            end else begin
              seq     <= seq + 1'b1;
              rd_addr <= (rd_addr == ADDR_TOP) ? '0 : rd_addr + 1'b1;
            end
          end
        end
        default: phase <= PH_FILL;
      endcase
    end
  end

  assign in_ready  = (phase == PH_FILL);
  assign out_valid = (phase == PH_SEND);
  assign out_data  = mem[rd_addr];
  assign out_sof   = out_valid && (seq == '0);
  assign out_last  = out_valid && (seq == SEQ_TOP);

  AST_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)); // R2
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sof) && $stable(out_last))); // R5
  AST_TX_FIRST_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sof); // R4
  AST_TX_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)); // R2
endmodule

// File: rtl/cpx_strip.sv
module cpx_strip #(
  parameter int DW  = 16,
  parameter int BLK = 8,
  parameter int PFX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  localparam int FRM = BLK + PFX;
  localparam int SW  = $clog2(FRM);
  localparam logic [SW-1:0] SEQ_TOP  = SW'(FRM - 1);
  localparam logic [SW-1:0] KEEP_BEG = SW'(PFX);

  logic [SW-1:0] pos;
  logic          locked;
  logic [SW-1:0] cur_pos;
  logic          cur_lock;
  logic          keep;
  logic          take_in;

  // A flagged sample always counts as frame index 0.
  assign cur_pos  = in_sof ? '0 : pos;
  assign cur_lock = locked || in_sof;
  assign keep     = cur_lock && (cur_pos >= KEEP_BEG);

  assign in_ready  = keep ? out_ready : 1'b1;
  assign out_valid = in_valid && keep;
  assign out_data  = in_data;
  assign out_last  = out_valid && (cur_pos == SEQ_TOP);
  assign take_in   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos    <= '0;
      locked <= 1'b0;
    end else if (take_in) begin
      locked <= cur_lock;
      pos    <= (cur_pos == SEQ_TOP) ? '0 : cur_pos + 1'b1;
    end
  end

  AST_RX_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !in_sof) |-> (!out_valid && in_ready)); // R6
  AST_RX_SOF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |-> (!out_valid && in_ready)); // R7
  AST_RX_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R9
  AST_RX_LAST_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (pos == '0)); // R11
endmodule

// File: rtl/cpx_unit.sv
module cpx_unit #(
  parameter int DW  = 16,
  parameter int BLK = 8,
  parameter int PFX = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_in_valid,
  output logic          tx_in_ready,
  input  logic [DW-1:0] tx_in_data,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  output logic          tx_out_sof,
  output logic          tx_out_last,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data,
  input  logic          rx_in_sof,
  output logic          rx_out_valid,
  input  logic          rx_out_ready,
  output logic [DW-1:0] rx_out_data,
  output logic          rx_out_last
);
  generate
    if (PFX < 1 || PFX >= BLK) begin : g_bad_cfg
      $error("cpx_unit: prefix length must be in 1..BLK-1");
    end
  endgenerate

  cpx_insert #(.DW(DW), .BLK(BLK), .PFX(PFX)) u_insert (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   (tx_in_data),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  (tx_out_data),
    .out_sof   (tx_out_sof),
    .out_last  (tx_out_last)
  );

  cpx_strip #(.DW(DW), .BLK(BLK), .PFX(PFX)) u_strip (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   (rx_in_data),
    .in_sof    (rx_in_sof),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  (rx_out_data),
    .out_last  (rx_out_last)
  );

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (tx_in_ready && !tx_out_valid)); // R1
endmodule

// File: tb/cpx_unit_tb.sv
module cpx_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int BLK = 8;
  localparam int PFX = 3;
  localparam int FRM = BLK + PFX;
  localparam int TX_FRAMES = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in_valid = 1'b0, tx_in_ready;
  logic [DW-1:0] tx_in_data = '0;
  logic tx_out_valid, tx_out_ready = 1'b0;
  logic [DW-1:0] tx_out_data;
  logic tx_out_sof, tx_out_last;
  logic rx_in_valid = 1'b0, rx_in_ready;
  logic [DW-1:0] rx_in_data = '0;
  logic rx_in_sof = 1'b0;
  logic rx_out_valid, rx_out_ready = 1'b0;
  logic [DW-1:0] rx_out_data;
  logic rx_out_last;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpx_unit #(.DW(DW), .BLK(BLK), .PFX(PFX)) u_dut (.*);

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // receive script
  int    rx_dat[$];
  bit    rx_sf[$];
  string rx_tag[$];
  int    rx_seed = 1000;

  task automatic add_rx(input int n, input bit flag_first, input string tag);
    for (int i = 0; i < n; i++) begin
      rx_dat.push_back(rx_seed);
      rx_sf.push_back(flag_first && (i == 0));
      rx_tag.push_back(tag);
      rx_seed++;
    end
  endtask

  // transmit model state
  int tx_blk[$];
  int tx_frm[$];
  int tx_pos = 0;
  int tx_next = 1;
  int tx_done = 0;
  // receive model state
  bit rx_lock = 0;
  int rx_pos = 0;

  initial begin
    int cyc;
    bit e_in_rdy, e_out_vld, e_sof, e_last, keep, e_lock, tx_held, rx_held;
    int e_pos;
    string tg;

    add_rx(4, 0, "R6");
    add_rx(FRM, 1, "R7");
    add_rx(FRM, 0, "R11");
    add_rx(5, 1, "R10");
    add_rx(FRM, 1, "R10");
    add_rx(FRM, 1, "R9");
    add_rx(FRM, 0, "R11");
    add_rx(FRM, 1, "R7");

    repeat (3) @(negedge clk);
    #1;
    chk(tx_in_ready == 1'b1, "R1", "tx_in_ready in reset", tx_in_ready, 1);
    chk(tx_out_valid == 1'b0, "R1", "tx_out_valid in reset", tx_out_valid, 0);
    chk(rx_out_valid == 1'b0, "R1", "rx_out_valid in reset", rx_out_valid, 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(tx_in_ready == 1'b1, "R1", "tx_in_ready after reset", tx_in_ready, 1);
    chk(tx_out_valid == 1'b0, "R1", "tx_out_valid after reset", tx_out_valid, 0);

    cyc = 0;
    tx_held = 0;
    rx_held = 0;
    while ((rx_dat.size() > 0 || tx_done < TX_FRAMES) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      // drive inputs
      if (!tx_held) tx_in_valid = ($urandom % 10) < 7;
      tx_in_data   = DW'(tx_next);
      tx_out_ready = (tx_done < 2) ? 1'b1 : (($urandom % 10) < 5);
      if (rx_dat.size() == 0) begin
        rx_in_valid = 1'b0;
        rx_in_sof   = 1'b0;
      end else begin
        if (!rx_held) rx_in_valid = ($urandom % 10) < 8;
        rx_in_data = DW'(rx_dat[0]);
        rx_in_sof  = rx_in_valid && rx_sf[0];
      end
      rx_out_ready = ($urandom % 10) < 6;
      #1;

      // transmit compare
      e_in_rdy  = (tx_frm.size() == 0);
      e_out_vld = (tx_frm.size() > 0);
      chk(tx_in_ready == e_in_rdy, "R2", "tx_in_ready", tx_in_ready, e_in_rdy);
      chk(tx_out_valid == e_out_vld, "R2", "tx_out_valid", tx_out_valid, e_out_vld);
      if (e_out_vld) begin
        e_sof  = (tx_pos == 0);
        e_last = (tx_pos == FRM - 1);
        chk(tx_out_data == DW'(tx_frm[0]), "R3/R5", "tx_out_data", int'(tx_out_data), tx_frm[0]);
        chk(tx_out_sof == e_sof, "R4", "tx_out_sof", tx_out_sof, e_sof);
        chk(tx_out_last == e_last, "R4", "tx_out_last", tx_out_last, e_last);
      end
      // transmit model step (the coming edge)
      tx_held = tx_in_valid && !e_in_rdy;
      if (tx_in_valid && e_in_rdy) begin
        tx_blk.push_back(tx_next);
        tx_next++;
        if (tx_blk.size() == BLK) begin
          for (int i = 0; i < PFX; i++) tx_frm.push_back(tx_blk[BLK - PFX + i]);
          for (int i = 0; i < BLK; i++) tx_frm.push_back(tx_blk[i]);
          tx_blk.delete();
        end
      end
      if (e_out_vld && tx_out_ready) begin
        void'(tx_frm.pop_front());
        if (tx_pos == FRM - 1) begin
          tx_pos = 0;
          tx_done++;
        end else tx_pos++;
      end

      // receive compare
      if (rx_in_valid) begin
        tg     = rx_tag[0];
        e_pos  = rx_sf[0] ? 0 : rx_pos;
        e_lock = rx_lock || rx_sf[0];
        keep   = e_lock && (e_pos >= PFX);
        e_in_rdy = keep ? rx_out_ready : 1'b1;
        chk(rx_in_ready == e_in_rdy, "R9", "rx_in_ready", rx_in_ready, e_in_rdy);
        chk(rx_out_valid == keep, tg, "rx_out_valid", rx_out_valid, keep);
        if (keep) begin
          e_last = (e_pos == FRM - 1);
          chk(rx_out_data == DW'(rx_dat[0]), tg, "rx_out_data", int'(rx_out_data), rx_dat[0]);
          chk(rx_out_last == e_last, "R8", "rx_out_last", rx_out_last, e_last);
        end
        rx_held = !e_in_rdy;
        if (e_in_rdy) begin
          void'(rx_dat.pop_front());
          void'(rx_sf.pop_front());
          void'(rx_tag.pop_front());
          rx_lock = e_lock;
          rx_pos  = (e_pos == FRM - 1) ? 0 : e_pos + 1;
        end
      end else begin
        rx_held = 1'b0;
        chk(rx_out_valid == 1'b0, "R6", "rx_out_valid idle", rx_out_valid, 0);
      end
    end

    if (cyc >= 20000) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, rx left %0d expected 0", rx_dat.size());
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule